// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block watches the write strobes of an asynchronous byte-wide flash bus and recognises the multi-write command sequences that such a device accepts. A system clock samples the bus. Each completed write is qualified and filtered for glitches. It then goes to a sequence tracker, which follows the unlock prefix and the command byte. When a full command has arrived, the block emits a one-cycle command pulse that carries the command kind, the latched address and the latched data. The array controller downstream acts on that pulse.

The block holds two flags. The first is the one-time boot-region lock, which stays set until reset. The second is the identification-mode flag. A program request aimed at the locked boot region is dropped. An erase issued after locking is passed on with a flag that tells the array to spare the boot region. While identification mode is active, a bus read of address 2 returns the lock state. A parameter places the 16 KB boot region either at the bottom or at the top of the address space.

The command output has a valid strobe only and no ready. A flash bus cannot be stalled, so the consumer must take every pulse in the cycle it appears. Writes that arrive while `busy_i` is high are discarded, not held back.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Every command sequence except the lone exit begins with data 0xAA written to address 0x5555, followed by 0x55 written to 0x2AAA. Only address bits 14:0 are compared for these fixed addresses.
- R2: The sequence prefix, 0xA0 to 0x5555, then one write to any address emits a PROGRAM pulse (`cmd_kind_o`=1) carrying that write's address and data.
- R3: The sequence prefix, 0x80 to 0x5555, 0xAA to 0x5555, 0x55 to 0x2AAA, then a last write to 0x5555 emits ERASE (kind 2) for data 0x10 and LOCK (kind 3) for data 0x40. Any other last byte emits nothing.
- R4: The sequence prefix then 0x90 to 0x5555 emits ID_ENTER (kind 4) and sets `id_mode_o`. Two sequences emit ID_LEAVE (kind 5) and clear `id_mode_o`: the prefix then 0xF0 to 0x5555, or a single write of 0xF0 to any address.
- R5: A write that does not match the next expected step returns the tracker to idle. That same write does not start a new sequence, unless its data is 0xF0, in which case it acts as a lone exit.
- R6: A LOCK command sets `locked_o`, and only reset clears it. While locked, a PROGRAM whose address lies in the boot region emits no pulse. An ERASE is emitted with `cmd_keep_boot_o`=1; before locking it carries 0.
- R7: With `TOP_BOOT`=0 the boot region is 0x00000–0x03FFF. With `TOP_BOOT`=1 it is 0x7C000–0x7FFFF. Addresses outside the region are never blocked.
- R8: A write counts only while `ce_n_i` is low, `we_n_i` is low and `oe_n_i` is high. Strobe activity under any other combination is ignored.
- R9: The address is taken when the write becomes active, that is, when the later of chip-enable and write-enable falls. The data is the value present in the last active cycle, when the earlier of the two rises.
- R10: A write that completes while `busy_i` is high is ignored and does not advance or reset the tracker.
- R11: A write whose synchronised active width is shorter than `MIN_LOW` clock cycles is discarded.
- R12: While `id_mode_o` is 1, a read cycle (`ce_n_i`=0, `oe_n_i`=0, `we_n_i`=1) at address 0x00002 drives `id_rd_valid_o`=1 and `id_rd_data_o`={7'b0, lock flag}. Outside identification mode `id_rd_valid_o` is 0.
- R13: `cmd_valid_o` is high for exactly one cycle per recognised command, and the command fields are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | 19 | Bus address |
| data_i | input | 8 | Bus write data |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| busy_i | input | 1 | Array operation in progress; writes ignored |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_kind_o | output | 3 | 1 program, 2 erase, 3 lock, 4 id enter, 5 id leave |
| cmd_addr_o | output | 19 | Address of the final write |
| cmd_data_o | output | 8 | Data of the final write |
| cmd_keep_boot_o | output | 1 | Erase must spare the boot region |
| locked_o | output | 1 | Boot region lock flag |
| id_mode_o | output | 1 | Identification mode flag |
| id_rd_valid_o | output | 1 | Identification read of the lock location active |
| id_rd_data_o | output | 8 | Identification read data |

## Verification
Two functions can act on the same write. One is the unmatched-write reset of the tracker. The other is the lone 0xF0 exit, and it can fall in the same cycle as the reset. The bench provokes this by sending 0xAA to 0x5555 in identification mode and then 0xF0 to an unrelated address. It expects an ID_LEAVE pulse and a cleared mode flag, and it expects no partially armed sequence afterwards. A second collision comes from writes that are ignored while a sequence is in progress: output-enable low, a glitch or busy. The bench inserts one of these between the prefix writes and then checks that the intended command still arrives. It also checks that no unexpected pulse appears.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [2:0] {
    CMD_NONE     = 3'd0,
    CMD_PROGRAM  = 3'd1,
    CMD_ERASE    = 3'd2,
    CMD_LOCK     = 3'd3,
    CMD_ID_ENTER = 3'd4,
    CMD_ID_LEAVE = 3'd5
  } cmd_kind_e;

  localparam int CMP_BITS = 15;
  localparam logic [CMP_BITS-1:0] KEY_ADDR_A = 15'h5555;
  localparam logic [CMP_BITS-1:0] KEY_ADDR_B = 15'h2AAA;
  localparam logic [7:0] KEY_DATA_A   = 8'hAA;
  localparam logic [7:0] KEY_DATA_B   = 8'h55;
  localparam logic [7:0] OP_PROGRAM   = 8'hA0;
  localparam logic [7:0] OP_EXTENDED  = 8'h80;
  localparam logic [7:0] OP_ID_ENTER  = 8'h90;
  localparam logic [7:0] OP_ID_LEAVE  = 8'hF0;
  localparam logic [7:0] OP_ERASE     = 8'h10;
  localparam logic [7:0] OP_LOCK      = 8'h40;
endpackage

// File: rtl/fcd_strobe.sv
module fcd_strobe #(
  parameter int AW          = 19,
  parameter int DW          = 8,
  parameter int MIN_LOW     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          ce_n_i,
  input  logic          oe_n_i,
  input  logic          we_n_i,
  output logic          wr_evt_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  localparam int CW = $clog2(MIN_LOW + 1);

  logic [SYNC_STAGES-1:0] ce_sh, oe_sh, we_sh;
  logic                   act, act_d;
  logic [CW-1:0]          width_cnt;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          ce_sh <= '1; oe_sh <= '1; we_sh <= '1;
        end else begin
          ce_sh <= ce_n_i; oe_sh <= oe_n_i; we_sh <= we_n_i;
        end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          ce_sh <= '1; oe_sh <= '1; we_sh <= '1;
        end else begin
          ce_sh <= {ce_sh[SYNC_STAGES-2:0], ce_n_i};
          oe_sh <= {oe_sh[SYNC_STAGES-2:0], oe_n_i};
          we_sh <= {we_sh[SYNC_STAGES-2:0], we_n_i};
        end
    end
  endgenerate

  // write phase: chip selected, write strobe low, output drive off
  assign act = !ce_sh[SYNC_STAGES-1] && !we_sh[SYNC_STAGES-1] && oe_sh[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_d     <= 1'b0;
      width_cnt <= '0;
      wr_evt_o  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      act_d <= act;
      if (act) begin
        if (width_cnt != CW'(MIN_LOW)) width_cnt <= width_cnt + 1'b1;
        wr_data_o <= data_i;
        if (!act_d) wr_addr_o <= addr_i;
      end else begin
        width_cnt <= '0;
      end
      wr_evt_o <= act_d && !act && (width_cnt == CW'(MIN_LOW));
    end
  end

  assert_min_width_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt_o |-> $past(width_cnt == CW'(MIN_LOW)))
    else $error("write event without minimum width");
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_evt_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          busy_i,
  output logic          req_valid_o,
  output cmd_kind_e     req_kind_o,
  output logic [AW-1:0] req_addr_o,
  output logic [DW-1:0] req_data_o
);
  typedef enum logic [2:0] {
    S_IDLE, S_KEY1, S_KEY2, S_PGM, S_EXT1, S_EXT2, S_EXT3
  } seq_state_e;

  seq_state_e state, nxt;
  cmd_kind_e  kind;
  logic       at_a, at_b, is_leave;

  assign at_a     = wr_addr_i[CMP_BITS-1:0] == KEY_ADDR_A;
  assign at_b     = wr_addr_i[CMP_BITS-1:0] == KEY_ADDR_B;
  assign is_leave = wr_data_i == OP_ID_LEAVE;

  always_comb begin
    nxt  = S_IDLE;
    kind = CMD_NONE;
    unique case (state)
      S_IDLE: begin
        if (at_a && wr_data_i == KEY_DATA_A) nxt = S_KEY1;
        else if (is_leave) kind = CMD_ID_LEAVE;
      end
      S_KEY1:
        if (at_b && wr_data_i == KEY_DATA_B) nxt = S_KEY2;
        else if (is_leave) kind = CMD_ID_LEAVE;
      S_KEY2: begin
        if (at_a && wr_data_i == OP_PROGRAM) nxt = S_PGM;
        else if (at_a && wr_data_i == OP_EXTENDED) nxt = S_EXT1;
        else if (at_a && wr_data_i == OP_ID_ENTER) kind = CMD_ID_ENTER;
        else if (is_leave) kind = CMD_ID_LEAVE;
      end
      S_PGM: kind = CMD_PROGRAM;
      S_EXT1:
        if (at_a && wr_data_i == KEY_DATA_A) nxt = S_EXT2;
        else if (is_leave) kind = CMD_ID_LEAVE;
      S_EXT2:
        if (at_b && wr_data_i == KEY_DATA_B) nxt = S_EXT3;
        else if (is_leave) kind = CMD_ID_LEAVE;
      S_EXT3: begin
        if (at_a && wr_data_i == OP_ERASE) kind = CMD_ERASE;
        else if (at_a && wr_data_i == OP_LOCK) kind = CMD_LOCK;
        else if (is_leave) kind = CMD_ID_LEAVE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      req_valid_o <= 1'b0;
      req_kind_o  <= CMD_NONE;
      req_addr_o  <= '0;
      req_data_o  <= '0;
    end else begin
      req_valid_o <= 1'b0;
      if (wr_evt_i && !busy_i) begin
        state       <= nxt;
        req_valid_o <= kind != CMD_NONE;
        req_kind_o  <= kind;
        req_addr_o  <= wr_addr_i;
        req_data_o  <= wr_data_i;
      end
    end
  end

  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt_i && busy_i) |=> ($stable(state) && !req_valid_o))
    else $error("write accepted while busy");

  assert_single_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |=> !req_valid_o)
    else $error("request longer than one cycle");
endmodule

// File: rtl/fcd_guard.sv
module fcd_guard
  import fcd_pkg::*;
#(
  parameter int AW        = 19,
  parameter int DW        = 8,
  parameter int BOOT_BITS = 14,
  parameter bit TOP_BOOT  = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid_i,
  input  cmd_kind_e     req_kind_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_data_i,
  output logic          cmd_valid_o,
  output cmd_kind_e     cmd_kind_o,
  output logic [AW-1:0] cmd_addr_o,
  output logic [DW-1:0] cmd_data_o,
  output logic          cmd_keep_boot_o,
  output logic          locked_o,
  output logic          id_mode_o
);
  logic req_in_boot, out_in_boot, blocked;

  generate
    if (TOP_BOOT) begin : g_top
      assign req_in_boot = &req_addr_i[AW-1:BOOT_BITS];
      assign out_in_boot = &cmd_addr_o[AW-1:BOOT_BITS];
    end else begin : g_bottom
      assign req_in_boot = ~|req_addr_i[AW-1:BOOT_BITS];
      assign out_in_boot = ~|cmd_addr_o[AW-1:BOOT_BITS];
    end
  endgenerate

  assign blocked = locked_o && req_in_boot && (req_kind_i == CMD_PROGRAM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid_o     <= 1'b0;
      cmd_kind_o      <= CMD_NONE;
      cmd_addr_o      <= '0;
      cmd_data_o      <= '0;
      cmd_keep_boot_o <= 1'b0;
      locked_o        <= 1'b0;
      id_mode_o       <= 1'b0;
    end else begin
      cmd_valid_o <= req_valid_i && !blocked;
      if (req_valid_i) begin
        cmd_kind_o      <= req_kind_i;
        cmd_addr_o      <= req_addr_i;
        cmd_data_o      <= req_data_i;
        cmd_keep_boot_o <= locked_o && (req_kind_i == CMD_ERASE);
        if (req_kind_i == CMD_LOCK)     locked_o  <= 1'b1;
        if (req_kind_i == CMD_ID_ENTER) id_mode_o <= 1'b1;
        if (req_kind_i == CMD_ID_LEAVE) id_mode_o <= 1'b0;
      end
    end
  end

  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |=> locked_o)
    else $error("lock flag cleared");

  assert_boot_protect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_kind_o == CMD_PROGRAM) |-> !(out_in_boot && $past(locked_o)))
    else $error("program into locked boot region");

  assert_id_leave_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_kind_o == CMD_ID_LEAVE) |-> !id_mode_o)
    else $error("identification mode not left");
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int AW          = 19,
  parameter int DW          = 8,
  parameter int MIN_LOW     = 3,
  parameter int SYNC_STAGES = 2,
  parameter int BOOT_BITS   = 14,
  parameter bit TOP_BOOT    = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          ce_n_i,
  input  logic          oe_n_i,
  input  logic          we_n_i,
  input  logic          busy_i,
  output logic          cmd_valid_o,
  output logic [2:0]    cmd_kind_o,
  output logic [AW-1:0] cmd_addr_o,
  output logic [DW-1:0] cmd_data_o,
  output logic          cmd_keep_boot_o,
  output logic          locked_o,
  output logic          id_mode_o,
  output logic          id_rd_valid_o,
  output logic [DW-1:0] id_rd_data_o
);
  localparam logic [AW-1:0] LOCK_INFO_ADDR = AW'(2);

  logic          wr_evt;
  logic [AW-1:0] wr_addr, req_addr;
  logic [DW-1:0] wr_data, req_data;
  logic          req_valid;
  cmd_kind_e     req_kind, out_kind;

  fcd_strobe #(.AW(AW), .DW(DW), .MIN_LOW(MIN_LOW), .SYNC_STAGES(SYNC_STAGES)) strobe_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .data_i(data_i),
    .ce_n_i(ce_n_i), .oe_n_i(oe_n_i), .we_n_i(we_n_i),
    .wr_evt_o(wr_evt), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  fcd_seq #(.AW(AW), .DW(DW)) seq_i (
    .clk(clk), .rst_n(rst_n), .wr_evt_i(wr_evt), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .busy_i(busy_i), .req_valid_o(req_valid),
    .req_kind_o(req_kind), .req_addr_o(req_addr), .req_data_o(req_data)
  );

  fcd_guard #(.AW(AW), .DW(DW), .BOOT_BITS(BOOT_BITS), .TOP_BOOT(TOP_BOOT)) guard_i (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_kind_i(req_kind),
    .req_addr_i(req_addr), .req_data_i(req_data), .cmd_valid_o(cmd_valid_o),
    .cmd_kind_o(out_kind), .cmd_addr_o(cmd_addr_o), .cmd_data_o(cmd_data_o),
    .cmd_keep_boot_o(cmd_keep_boot_o), .locked_o(locked_o), .id_mode_o(id_mode_o)
  );

  assign cmd_kind_o    = out_kind;
  assign id_rd_valid_o = id_mode_o && !ce_n_i && !oe_n_i && we_n_i && (addr_i == LOCK_INFO_ADDR);
  assign id_rd_data_o  = id_rd_valid_o ? {{(DW-1){1'b0}}, locked_o} : '0;

  assert_kind_known_R13: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> (cmd_kind_o != 3'd0 && cmd_kind_o <= 3'd5))
    else $error("command pulse without kind");
endmodule

// File: tb/flash_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb_top;
  localparam int AW = 19;
  localparam int DW = 8;
  localparam int K_PGM = 1, K_ERA = 2, K_LCK = 3, K_ENT = 4, K_LEV = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] data_i = '0;
  logic ce_n_i = 1'b1, oe_n_i = 1'b1, we_n_i = 1'b1, busy_i = 1'b0;
  logic cmd_valid_o, cmd_keep_boot_o, locked_o, id_mode_o, id_rd_valid_o;
  logic [2:0] cmd_kind_o;
  logic [AW-1:0] cmd_addr_o;
  logic [DW-1:0] cmd_data_o, id_rd_data_o;

  int checks = 0;
  int failures = 0;
  logic [30:0] exp_q[$];
  string tag_q[$];
  logic prev_valid = 1'b0;

  always #10 clk = ~clk;

  flash_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .data_i(data_i),
    .ce_n_i(ce_n_i), .oe_n_i(oe_n_i), .we_n_i(we_n_i), .busy_i(busy_i),
    .cmd_valid_o(cmd_valid_o), .cmd_kind_o(cmd_kind_o), .cmd_addr_o(cmd_addr_o),
    .cmd_data_o(cmd_data_o), .cmd_keep_boot_o(cmd_keep_boot_o), .locked_o(locked_o),
    .id_mode_o(id_mode_o), .id_rd_valid_o(id_rd_valid_o), .id_rd_data_o(id_rd_data_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a command pulse appears
  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_valid_o && prev_valid) check("R13 pulse width", 32'd2, 32'd1);
      if (cmd_valid_o) begin
        if (exp_q.size() == 0) begin
          check("R5 unexpected command", {29'd0, cmd_kind_o}, 32'd0);
        end else begin
          logic [30:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, {1'b0, cmd_kind_o, cmd_addr_o, cmd_data_o, cmd_keep_boot_o}, {1'b0, e});
        end
      end
    end
    prev_valid = cmd_valid_o;
  end

  task automatic expect_cmd(input int k, input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input bit keep, input string req);
    exp_q.push_back({k[2:0], a, d, keep});
    tag_q.push_back(req);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input int low = 6, input bit oe_low = 0, input bit ce_high = 0);
    @(negedge clk);
    addr_i = a; data_i = d; oe_n_i = oe_low ? 1'b0 : 1'b1;
    ce_n_i = ce_high ? 1'b1 : 1'b0;
    @(negedge clk);
    we_n_i = 1'b0;
    repeat (low) @(negedge clk);
    we_n_i = 1'b1;
    @(negedge clk);
    ce_n_i = 1'b1; oe_n_i = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic prefix();
    wr(19'h05555, 8'hAA);
    wr(19'h02AAA, 8'h55);
  endtask

  task automatic settle(input string req);
    repeat (12) @(negedge clk);
    check(req, exp_q.size(), 32'd0);
    exp_q.delete(); tag_q.delete();
  endtask

  task automatic id_read(input logic [AW-1:0] a, input bit v, input logic [7:0] d, input string req);
    @(negedge clk);
    addr_i = a; ce_n_i = 1'b0; oe_n_i = 1'b0; we_n_i = 1'b1;
    #1;
    check({req, " valid"}, id_rd_valid_o, v);
    check({req, " data"}, id_rd_data_o, d);
    @(negedge clk);
    ce_n_i = 1'b1; oe_n_i = 1'b1;
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R13 reset valid", cmd_valid_o, 0);
    check("R6 reset lock", locked_o, 0);
    check("R4 reset id mode", id_mode_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2: prefix with upper address bits set still matches
    wr(19'h45555, 8'hAA); wr(19'h72AAA, 8'h55); wr(19'h15555, 8'hA0);
    expect_cmd(K_PGM, 19'h12345, 8'h3C, 0, "R2 program fields");
    wr(19'h12345, 8'h3C);
    settle("R1 partial address compare");

    // R8: writes with OE low or CE high between prefix steps are ignored
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55, 6, 1);
    wr(19'h02AAA, 8'h55, 6, 0, 1); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hA0);
    expect_cmd(K_PGM, 19'h20000, 8'h11, 0, "R8 qualified write");
    wr(19'h20000, 8'h11);
    settle("R8 ignored strobes");

    // R5: repeated first key breaks the sequence, no re-arm
    wr(19'h05555, 8'hAA); wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55);
    wr(19'h05555, 8'hA0); wr(19'h30000, 8'h77);
    settle("R5 mismatch returns idle");

    // R4 R12: identification entry, read, lone and full exits
    prefix(); expect_cmd(K_ENT, 19'h05555, 8'h90, 0, "R4 id enter");
    wr(19'h05555, 8'h90);
    settle("R4 enter seen");
    check("R4 id mode set", id_mode_o, 1);
    id_read(19'h00002, 1, 8'h00, "R12 id read unlocked");
    expect_cmd(K_LEV, 19'h01234, 8'hF0, 0, "R4 lone exit");
    wr(19'h01234, 8'hF0);
    settle("R4 lone exit seen");
    check("R4 id mode cleared", id_mode_o, 0);
    id_read(19'h00002, 0, 8'h00, "R12 no id read outside mode");
    prefix(); expect_cmd(K_ENT, 19'h05555, 8'h90, 0, "R4 id enter 2");
    wr(19'h05555, 8'h90);
    prefix(); expect_cmd(K_LEV, 19'h05555, 8'hF0, 0, "R4 full exit");
    wr(19'h05555, 8'hF0);
    settle("R4 full exit seen");
    check("R4 id mode cleared 2", id_mode_o, 0);
    // R5 exception: armed sequence then lone F0
    prefix(); expect_cmd(K_ENT, 19'h05555, 8'h90, 0, "R4 id enter 3");
    wr(19'h05555, 8'h90);
    wr(19'h05555, 8'hAA);
    expect_cmd(K_LEV, 19'h06000, 8'hF0, 0, "R5 F0 during sequence");
    wr(19'h06000, 8'hF0);
    wr(19'h05555, 8'hA0); wr(19'h31000, 8'h01);
    settle("R5 F0 exit and idle");
    check("R5 id mode cleared", id_mode_o, 0);

    // R9: address at start, data at end of the active phase
    prefix(); wr(19'h05555, 8'hA0);
    expect_cmd(K_PGM, 19'h11111, 8'h5A, 0, "R9 capture points");
    @(negedge clk);
    addr_i = 19'h11111; data_i = 8'h00; ce_n_i = 1'b0;
    @(negedge clk); we_n_i = 1'b0;
    repeat (4) @(negedge clk);
    addr_i = 19'h22222; data_i = 8'h5A;
    repeat (4) @(negedge clk);
    we_n_i = 1'b1;
    @(negedge clk); ce_n_i = 1'b1;
    settle("R9 seen");

    // R11: 2-cycle glitch ignored, MIN_LOW=3 write accepted
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55, 2); wr(19'h02AAA, 8'h55, 3);
    wr(19'h05555, 8'hA0);
    expect_cmd(K_PGM, 19'h23456, 8'h99, 0, "R11 glitch filter");
    wr(19'h23456, 8'h99);
    settle("R11 seen");

    // R10: busy write ignored without disturbing the tracker
    wr(19'h05555, 8'hAA);
    busy_i = 1'b1; wr(19'h02AAA, 8'h55); busy_i = 1'b0;
    wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hA0);
    expect_cmd(K_PGM, 19'h24000, 8'h42, 0, "R10 busy ignored");
    wr(19'h24000, 8'h42);
    settle("R10 seen");

    // R3: erase unlocked, bad last byte, lockout
    prefix(); wr(19'h05555, 8'h80); prefix();
    expect_cmd(K_ERA, 19'h05555, 8'h10, 0, "R3 erase unlocked");
    wr(19'h05555, 8'h10);
    prefix(); wr(19'h05555, 8'h80); prefix(); wr(19'h05555, 8'h22);
    settle("R3 erase and bad byte");
    check("R3 not yet locked", locked_o, 0);
    prefix(); wr(19'h05555, 8'h80); prefix();
    expect_cmd(K_LCK, 19'h05555, 8'h40, 0, "R3 lockout");
    wr(19'h05555, 8'h40);
    settle("R3 lockout seen");
    check("R6 lock set", locked_o, 1);

    // R6 R7: boot region protected, rest open, erase spares boot
    prefix(); wr(19'h05555, 8'hA0); wr(19'h01000, 8'h00);
    prefix(); wr(19'h05555, 8'hA0); wr(19'h03FFF, 8'h00);
    prefix(); wr(19'h05555, 8'hA0);
    expect_cmd(K_PGM, 19'h04000, 8'h12, 0, "R7 just above boot");
    wr(19'h04000, 8'h12);
    prefix(); wr(19'h05555, 8'hA0);
    expect_cmd(K_PGM, 19'h7C000, 8'h34, 0, "R7 top unprotected in bottom variant");
    wr(19'h7C000, 8'h34);
    prefix(); wr(19'h05555, 8'h80); prefix();
    expect_cmd(K_ERA, 19'h05555, 8'h10, 1, "R6 erase keeps boot");
    wr(19'h05555, 8'h10);
    settle("R6 boot protection");
    prefix(); expect_cmd(K_ENT, 19'h05555, 8'h90, 0, "R12 enter");
    wr(19'h05555, 8'h90);
    settle("R12 enter seen");
    id_read(19'h00002, 1, 8'h01, "R12 id read locked");
    id_read(19'h00003, 0, 8'h00, "R12 other address");
    check("R6 lock persists", locked_o, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule